// File: doc/BRIEF.md
# VLIW Bundle Execution Core

This block runs a program made of very-long-instruction bundles, one bundle at a time. Each bundle has five independent slots: two loads that each read memory through a pointer register and then bump that pointer, one store that does the same for a write, an integer add with an immediate, and a counted-loop branch. All slots see the register file as it was when the bundle began. All register results land together when the bundle finishes. This lets a loop body overlap work from several source iterations: a load can refill a register in the same bundle that the add consumes its old value.

Bundles come from a read-only program port addressed by the program counter. Data memory is split into two banks by the lowest address bit. Each bank has a request/ready handshake. The core issues the memory slots of a bundle in a fixed order. Loads in different banks run together. Loads in the same bank run one after the other. The store is issued only after every load of the bundle has finished. The bundle completes when its slowest access is done, and a one-cycle pulse marks that moment.

Top module: `vliw_bundle_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the program address is 0, no bank request is raised and the done pulse is low. All eight registers reset to zero.
- R2: A bundle is taken from the program port in one fetch cycle. It then executes, and commits in a cycle where `bundle_done_o` is high for exactly one cycle. The next fetch follows at once. Without a taken branch the program address becomes the old address plus one.
- R3: Every slot reads its source and pointer registers as they stood before the bundle. A register written by one slot is not seen by another slot of the same bundle.
- R4: A load slot (fields enable, destination, pointer) reads the word at the pre-bundle pointer value into its destination. It then writes pointer+1 back.
- R5: The store slot (fields enable, source, pointer) writes the pre-bundle source value to the pre-bundle pointer address. It then writes pointer+1 back.
- R6: The add slot (fields enable, destination, a, b, 8-bit imm) writes a + b + sign-extended imm.
- R7: The loop slot (fields enable, target) decrements register 7. If the new value is nonzero, the next address is the target. Otherwise execution falls through to the old address plus one.
- R8: An access goes to the bank given by address bit 0. A raised request keeps its address, write flag and data unchanged until that bank's ready is seen, and each bank carries one access at a time.
- R9: Two loads whose addresses differ in bit 0 are issued together. Two loads whose addresses share bit 0 are issued load 0 first, then load 1.
- R10: The store is issued only after all loads of the bundle have completed, so a load and a store to one address return the old word.
- R11: Let L be the cycles from request to ready, inclusive. The execute phase lasts 1 cycle with no access. Loads take L cycles on separate banks or 2L on one bank. A store adds L more. The bundle period is execute length + 2.
- R12: When several slots write one register, one value wins, in this order from highest: load 1 data, load 0 data, add result, pointer increments, loop decrement.
- R13: A slot with its enable bit clear issues no access and changes no register. A bundle with every enable clear takes 3 cycles and steps the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| imem_addr_o | output | 6 | Program address (current bundle) |
| imem_data_i | input | 46 | Bundle word at `imem_addr_o` |
| mem_req_o | output | 2 | Per-bank access request |
| mem_we_o | output | 2 | Per-bank write flag |
| mem_addr_o | output | 32 | Per-bank address, 16 bits each, bank 0 in the low half |
| mem_wdata_o | output | 32 | Per-bank write data |
| mem_rdata_i | input | 32 | Per-bank read data, valid with ready |
| mem_ready_i | input | 2 | Per-bank access completion |
| bundle_done_o | output | 1 | One-cycle commit pulse |

## Verification
Register results become visible only at the commit edge. A value is therefore checked by a later store that puts it in memory, and the memory is read only after the done pulse of that store's bundle. The bench's memory raises ready in the second cycle of a request, so L is 2. Bundle periods are counted as negative clock edges from one done pulse to the next. The expected counts (3, 4, 6 or 8) are derived from R11 before the run. The program address is sampled at the negative edge after a commit, which is the first cycle that shows the updated value.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
    localparam int DW       = 16;
    localparam int NREG     = 8;
    localparam int RIW      = $clog2(NREG);
    localparam int PCW      = 6;
    localparam int IMMW     = 8;
    localparam int NBANK    = 2;
    localparam int LOOP_REG = NREG - 1;
    localparam int NWR      = 7;

    typedef logic [RIW-1:0] ridx_t;

    typedef struct packed {
        logic  en;
        ridx_t dst;
        ridx_t ptr;
    } ld_slot_t;

    typedef struct packed {
        logic  en;
        ridx_t src;
        ridx_t ptr;
    } st_slot_t;

    typedef struct packed {
        logic            en;
        ridx_t           dst;
        ridx_t           a;
        ridx_t           b;
        logic [IMMW-1:0] imm;
    } add_slot_t;

    typedef struct packed {
        logic           en;
        logic [PCW-1:0] tgt;
    } loop_slot_t;

    typedef struct packed {
        ld_slot_t   ld0;
        ld_slot_t   ld1;
        st_slot_t   st;
        add_slot_t  add;
        loop_slot_t lp;
    } bundle_t;

    localparam int BW = $bits(bundle_t);

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_EXEC   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_t;
endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile
    import vliw_pkg::*;
#(
    parameter int NW = NWR
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       commit_i,
    input  logic [NW-1:0]              wr_en_i,
    input  logic [NW-1:0][RIW-1:0]     wr_idx_i,
    input  logic [NW-1:0][DW-1:0]      wr_data_i,
    output logic [NREG-1:0][DW-1:0]    rf_o
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } rf_st_t;

    rf_st_t rf_d, rf_q;

    // Later ports override earlier ones: the port order is the priority.
    always_comb begin
        rf_d = rf_q;
        if (commit_i) begin
            for (int w = 0; w < NW; w++) begin
                if (wr_en_i[w]) begin
                    rf_d.r[wr_idx_i[w]] = wr_data_i[w];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rf_o = rf_q.r;
endmodule

// File: rtl/vliw_mem_sched.sv
module vliw_mem_sched
    import vliw_pkg::*;
(
    input  logic                      active_i,
    input  logic [1:0]                ld_pend_i,
    input  logic                      st_pend_i,
    input  logic [1:0][DW-1:0]        ld_addr_i,
    input  logic [DW-1:0]             st_addr_i,
    input  logic [DW-1:0]             st_data_i,
    input  logic [NBANK-1:0]          bank_ready_i,
    output logic [NBANK-1:0]          bank_req_o,
    output logic [NBANK-1:0]          bank_we_o,
    output logic [NBANK-1:0][DW-1:0]  bank_addr_o,
    output logic [NBANK-1:0][DW-1:0]  bank_wdata_o,
    output logic [1:0]                ld_ack_o,
    output logic                      st_ack_o
);
    logic       bk0, bk1, bks;
    logic [1:0] ld_go;
    logic       st_go;

    assign bk0 = ld_addr_i[0][0];
    assign bk1 = ld_addr_i[1][0];
    assign bks = st_addr_i[0];

    // Load 0 always may go; load 1 waits while load 0 owns its bank;
    // the store waits for every load of the bundle.
    assign ld_go[0] = active_i && ld_pend_i[0];
    assign ld_go[1] = active_i && ld_pend_i[1] && !(ld_go[0] && (bk0 == bk1));
    assign st_go    = active_i && st_pend_i && !ld_pend_i[0] && !ld_pend_i[1];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel0, sel1, sels;
        assign sel0 = ld_go[0] && (bk0 == 1'(b));
        assign sel1 = ld_go[1] && (bk1 == 1'(b));
        assign sels = st_go    && (bks == 1'(b));

        assign bank_req_o[b]   = sel0 || sel1 || sels;
        assign bank_we_o[b]    = sels;
        assign bank_wdata_o[b] = st_data_i;
        always_comb begin
            if (sel0) begin
                bank_addr_o[b] = ld_addr_i[0];
            end else if (sel1) begin
                bank_addr_o[b] = ld_addr_i[1];
            end else begin
                bank_addr_o[b] = st_addr_i;
            end
        end
    end

    assign ld_ack_o[0] = ld_go[0] && bank_ready_i[bk0];
    assign ld_ack_o[1] = ld_go[1] && bank_ready_i[bk1];
    assign st_ack_o    = st_go    && bank_ready_i[bks];
endmodule

// File: rtl/vliw_bundle_core.sv
module vliw_bundle_core
    import vliw_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    output logic [PCW-1:0]       imem_addr_o,
    input  logic [BW-1:0]        imem_data_i,
    output logic [NBANK-1:0]     mem_req_o,
    output logic [NBANK-1:0]     mem_we_o,
    output logic [NBANK*DW-1:0]  mem_addr_o,
    output logic [NBANK*DW-1:0]  mem_wdata_o,
    input  logic [NBANK*DW-1:0]  mem_rdata_i,
    input  logic [NBANK-1:0]     mem_ready_i,
    output logic                 bundle_done_o
);
    typedef struct packed {
        phase_t            ph;
        logic [PCW-1:0]    pc;
        bundle_t           ir;
        logic [1:0]        ld_pend;
        logic              st_pend;
        logic [1:0][DW-1:0] ld_val;
    } core_st_t;

    core_st_t cur_q, nxt_d;

    logic [NREG-1:0][DW-1:0]  rf;
    logic [NBANK-1:0][DW-1:0] rdata;
    logic [NBANK-1:0][DW-1:0] bank_addr, bank_wdata;
    logic [1:0][DW-1:0]       ld_addr;
    logic [DW-1:0]            st_addr, st_data, add_res, cnt_new;
    logic [1:0]               ld_ack;
    logic                     st_ack, active, commit, branch;
    logic [NWR-1:0]           wr_en;
    logic [NWR-1:0][RIW-1:0]  wr_idx;
    logic [NWR-1:0][DW-1:0]   wr_data;

    assign rdata = mem_rdata_i;

    // Operand reads: the file only changes at commit, so these are the
    // values from before the bundle for the whole execute phase.
    assign ld_addr[0] = rf[cur_q.ir.ld0.ptr];
    assign ld_addr[1] = rf[cur_q.ir.ld1.ptr];
    assign st_addr    = rf[cur_q.ir.st.ptr];
    assign st_data    = rf[cur_q.ir.st.src];
    assign add_res    = rf[cur_q.ir.add.a] + rf[cur_q.ir.add.b]
                      + {{(DW-IMMW){cur_q.ir.add.imm[IMMW-1]}}, cur_q.ir.add.imm};
    assign cnt_new    = rf[LOOP_REG] - DW'(1);
    assign branch     = cur_q.ir.lp.en && (cnt_new != '0);

    assign active = (cur_q.ph == PH_EXEC);
    assign commit = (cur_q.ph == PH_COMMIT);

    vliw_mem_sched u_sched (
        .active_i     (active),
        .ld_pend_i    (cur_q.ld_pend),
        .st_pend_i    (cur_q.st_pend),
        .ld_addr_i    (ld_addr),
        .st_addr_i    (st_addr),
        .st_data_i    (st_data),
        .bank_ready_i (mem_ready_i),
        .bank_req_o   (mem_req_o),
        .bank_we_o    (mem_we_o),
        .bank_addr_o  (bank_addr),
        .bank_wdata_o (bank_wdata),
        .ld_ack_o     (ld_ack),
        .st_ack_o     (st_ack)
    );

    assign mem_addr_o  = bank_addr;
    assign mem_wdata_o = bank_wdata;

    // Write ports, lowest priority first.
    always_comb begin
        wr_en[0] = cur_q.ir.lp.en;  wr_idx[0] = RIW'(LOOP_REG);    wr_data[0] = cnt_new;
        wr_en[1] = cur_q.ir.st.en;  wr_idx[1] = cur_q.ir.st.ptr;   wr_data[1] = st_addr + DW'(1);
        wr_en[2] = cur_q.ir.ld1.en; wr_idx[2] = cur_q.ir.ld1.ptr;  wr_data[2] = ld_addr[1] + DW'(1);
        wr_en[3] = cur_q.ir.ld0.en; wr_idx[3] = cur_q.ir.ld0.ptr;  wr_data[3] = ld_addr[0] + DW'(1);
        wr_en[4] = cur_q.ir.add.en; wr_idx[4] = cur_q.ir.add.dst;  wr_data[4] = add_res;
        wr_en[5] = cur_q.ir.ld0.en; wr_idx[5] = cur_q.ir.ld0.dst;  wr_data[5] = cur_q.ld_val[0];
        wr_en[6] = cur_q.ir.ld1.en; wr_idx[6] = cur_q.ir.ld1.dst;  wr_data[6] = cur_q.ld_val[1];
    end

    vliw_regfile #(.NW(NWR)) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .commit_i  (commit),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rf_o      (rf)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.ph)
            PH_FETCH: begin
                nxt_d.ir      = bundle_t'(imem_data_i);
                nxt_d.ld_pend = {nxt_d.ir.ld1.en, nxt_d.ir.ld0.en};
                nxt_d.st_pend = nxt_d.ir.st.en;
                nxt_d.ph      = PH_EXEC;
            end
            PH_EXEC: begin
                for (int i = 0; i < 2; i++) begin
                    if (ld_ack[i]) begin
                        nxt_d.ld_pend[i] = 1'b0;
                        nxt_d.ld_val[i]  = rdata[ld_addr[i][0]];
                    end
                end
                if (st_ack) begin
                    nxt_d.st_pend = 1'b0;
                end
                if ((nxt_d.ld_pend == 2'b00) && !nxt_d.st_pend) begin
                    nxt_d.ph = PH_COMMIT;
                end
            end
            PH_COMMIT: begin
                nxt_d.pc = branch ? cur_q.ir.lp.tgt : cur_q.pc + PCW'(1);
                nxt_d.ph = PH_FETCH;
            end
            default: nxt_d.ph = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign imem_addr_o   = cur_q.pc;
    assign bundle_done_o = commit;
endmodule

// File: rtl/vliw_bundle_core_chk.sv
module vliw_bundle_core_chk
    import vliw_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [PCW-1:0]       imem_addr_o,
    input logic [NBANK-1:0]     mem_req_o,
    input logic [NBANK-1:0]     mem_we_o,
    input logic [NBANK*DW-1:0]  mem_addr_o,
    input logic [NBANK-1:0]     mem_ready_i,
    input logic                 bundle_done_o
);
    a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bundle_done_o |=> !bundle_done_o);

    a_r2_quiet_around_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bundle_done_o |-> (mem_req_o == '0) ##1 (mem_req_o == '0));

    a_r2_pc_moves_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bundle_done_o |=> $stable(imem_addr_o));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        a_r8_bank_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mem_req_o[b] |-> (mem_addr_o[b*DW] == 1'(b)));

        a_r8_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mem_req_o[b] && !mem_ready_i[b]) |=>
                (mem_req_o[b] && $stable(mem_addr_o[b*DW +: DW]) && $stable(mem_we_o[b])));

        a_r10_store_after_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mem_req_o[b] && mem_we_o[b]) |-> !(mem_req_o[1-b] && !mem_we_o[1-b]));

        a_r8_write_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mem_we_o[b] |-> mem_req_o[b]);
    end
endmodule

bind vliw_bundle_core vliw_bundle_core_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .imem_addr_o   (imem_addr_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ready_i   (mem_ready_i),
    .bundle_done_o (bundle_done_o)
);

// File: tb/test_vliw_bundle_core.sv
module test_vliw_bundle_core;
    import vliw_pkg::*;

    localparam int LAT  = 1;     // ready in the second request cycle: L = 2
    localparam int MEMN = 256;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [PCW-1:0]       imem_addr;
    logic [BW-1:0]        imem_data;
    logic [NBANK-1:0]     req, we, ready;
    logic [NBANK*DW-1:0]  addr, wdata, rdata;
    logic                 done;

    bundle_t     prog [2**PCW];
    logic [DW-1:0] mem [MEMN];
    int          cnt [NBANK];
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;   // 8 ns period

    assign imem_data = prog[imem_addr];

    vliw_bundle_core i_vliw_bundle_core (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .imem_addr_o   (imem_addr),
        .imem_data_i   (imem_data),
        .mem_req_o     (req),
        .mem_we_o      (we),
        .mem_addr_o    (addr),
        .mem_wdata_o   (wdata),
        .mem_rdata_i   (rdata),
        .mem_ready_i   (ready),
        .bundle_done_o (done)
    );

    function automatic logic [DW-1:0] init_word(int i);
        return DW'(16'h1000 + 7 * i);
    endfunction

    // Banked memory model
    for (genvar b = 0; b < NBANK; b++) begin : g_mem
        assign ready[b] = req[b] && (cnt[b] == LAT);
        assign rdata[b*DW +: DW] = mem[addr[b*DW +: 8]];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= init_word(i);
            for (int b = 0; b < NBANK; b++) cnt[b] <= 0;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (req[b] && ready[b]) begin
                    cnt[b] <= 0;
                    if (we[b]) mem[addr[b*DW +: 8]] <= wdata[b*DW +: DW];
                end else if (req[b]) begin
                    cnt[b] <= cnt[b] + 1;
                end else begin
                    cnt[b] <= 0;
                end
            end
        end
    end

    function automatic ld_slot_t LD(int dst, int ptr);
        return '{en: 1'b1, dst: RIW'(dst), ptr: RIW'(ptr)};
    endfunction
    function automatic st_slot_t ST(int src, int ptr);
        return '{en: 1'b1, src: RIW'(src), ptr: RIW'(ptr)};
    endfunction
    function automatic add_slot_t ADD(int dst, int a, int b, int imm);
        return '{en: 1'b1, dst: RIW'(dst), a: RIW'(a), b: RIW'(b), imm: IMMW'(imm)};
    endfunction
    function automatic loop_slot_t LP(int tgt);
        return '{en: 1'b1, tgt: PCW'(tgt)};
    endfunction

    task automatic check(string req_s, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req_s, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 2**PCW; i++) prog[i] = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    task automatic period(output int k, output logic [NBANK-1:0] any_req);
        k = 0;
        any_req = '0;
        do begin
            @(negedge clk);
            k++;
            any_req |= req;
        end while (!done);
    endtask

    typedef struct packed {
        logic       l0, l1, s;
        logic [7:0] pa, pb, ps;
        logic [7:0] k;
    } row_t;

    // Bundle period per R11 with L = 2
    localparam row_t ROWS [8] = '{
        '{1'b0, 1'b0, 1'b0, 8'd16, 8'd33, 8'd48, 8'd3},
        '{1'b1, 1'b0, 1'b0, 8'd16, 8'd33, 8'd48, 8'd4},
        '{1'b1, 1'b1, 1'b0, 8'd16, 8'd33, 8'd48, 8'd4},
        '{1'b1, 1'b1, 1'b0, 8'd16, 8'd32, 8'd48, 8'd6},
        '{1'b1, 1'b1, 1'b1, 8'd16, 8'd33, 8'd48, 8'd6},
        '{1'b1, 1'b1, 1'b1, 8'd16, 8'd32, 8'd48, 8'd8},
        '{1'b0, 1'b0, 1'b1, 8'd16, 8'd33, 8'd49, 8'd4},
        '{1'b0, 1'b1, 1'b0, 8'd16, 8'd33, 8'd48, 8'd4}
    };

    initial begin
        int               k;
        logic [NBANK-1:0] rq;

        // R1: reset state
        clear_prog();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pc in reset", int'(imem_addr), 0);
        check("R1 no request in reset", int'(req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done low after reset", int'(done), 0);

        // Table: R9 R11 timing (R8 bank split by address bit 0)
        foreach (ROWS[r]) begin
            clear_prog();
            prog[0].add = ADD(1, 0, 0, int'(ROWS[r].pa));
            prog[1].add = ADD(2, 0, 0, int'(ROWS[r].pb));
            prog[2].add = ADD(3, 0, 0, int'(ROWS[r].ps));
            prog[3].ld0 = LD(4, 1);  prog[3].ld0.en = ROWS[r].l0;
            prog[3].ld1 = LD(5, 2);  prog[3].ld1.en = ROWS[r].l1;
            prog[3].st  = ST(6, 3);  prog[3].st.en  = ROWS[r].s;
            do_reset();
            wait_done(3);
            period(k, rq);
            check($sformatf("R9 R11 row %0d bundle period", r), k, int'(ROWS[r].k));
        end

        // Software-pipelined vector add: R3 R4 R5 R6 R7
        clear_prog();
        prog[0].add = ADD(1, 0, 0, 16);
        prog[1].add = ADD(2, 0, 0, 33);
        prog[2].add = ADD(3, 0, 0, 16);
        prog[3].add = ADD(7, 0, 0, 2);
        prog[4].ld0 = LD(4, 1);  prog[4].ld1 = LD(5, 2);
        prog[5].add = ADD(6, 4, 5, 0);
        prog[5].ld0 = LD(4, 1);  prog[5].ld1 = LD(5, 2);
        prog[6].st  = ST(6, 3);  prog[6].add = ADD(6, 4, 5, 0);
        prog[6].ld0 = LD(4, 1);  prog[6].ld1 = LD(5, 2);
        prog[6].lp  = LP(6);
        prog[7].st  = ST(6, 3);  prog[7].add = ADD(6, 4, 5, 0);
        prog[8].st  = ST(6, 3);
        do_reset();
        wait_done(7);
        @(negedge clk);
        check("R7 branch taken to target", int'(imem_addr), 6);
        wait_done(3);
        @(negedge clk);
        check("R7 fall-through at zero", int'(imem_addr), 9);
        for (int i = 0; i < 4; i++) begin
            check($sformatf("R3 R4 R5 R6 sum a[%0d]", i), int'(mem[16 + i]),
                  int'(DW'(init_word(16 + i) + init_word(33 + i))));
        end

        // R12 write priority
        clear_prog();
        prog[0].add = ADD(1, 0, 0, 40);
        prog[1].add = ADD(2, 0, 0, 50);
        prog[2].ld0 = LD(4, 1);  prog[2].add = ADD(4, 0, 0, 7);
        prog[3].ld0 = LD(2, 2);
        prog[4].ld0 = LD(5, 1);  prog[4].ld1 = LD(5, 3);
        prog[5].add = ADD(3, 0, 0, 60);
        prog[6].st  = ST(4, 3);
        prog[7].st  = ST(2, 3);
        prog[8].st  = ST(5, 3);
        do_reset();
        wait_done(9);
        check("R12 load beats add", int'(mem[60]), int'(init_word(40)));
        check("R12 load beats pointer increment", int'(mem[61]), int'(init_word(50)));
        check("R12 load 1 beats load 0", int'(mem[62]), int'(init_word(0)));

        // R10 load before store, R13 disabled slots
        clear_prog();
        prog[0].add = ADD(1, 0, 0, 70);
        prog[1].add = ADD(2, 0, 0, 5);
        prog[2].ld0 = LD(4, 1);  prog[2].st = ST(2, 1);
        prog[3].ld0 = LD(1, 1);  prog[3].ld1 = LD(1, 2);
        prog[3].st  = ST(2, 1);  prog[3].add = ADD(1, 0, 0, 99);
        prog[3].lp  = LP(0);
        prog[3].ld0.en = 1'b0; prog[3].ld1.en = 1'b0; prog[3].st.en = 1'b0;
        prog[3].add.en = 1'b0; prog[3].lp.en  = 1'b0;
        prog[4].add = ADD(3, 0, 0, 80);
        prog[5].st  = ST(4, 3);
        prog[6].st  = ST(1, 3);
        do_reset();
        wait_done(3);
        period(k, rq);
        check("R13 R2 disabled bundle period", k, 3);
        check("R13 disabled bundle requests", int'(rq), 0);
        @(negedge clk);
        check("R2 address steps by one", int'(imem_addr), 4);
        wait_done(3);
        check("R10 store landed", int'(mem[70]), 5);
        check("R10 load saw old word", int'(mem[80]), int'(init_word(70)));
        check("R13 pointer untouched by disabled slots", int'(mem[81]), 71);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule